// File: doc/BRIEF.md
# Egress Queue Scheduler with Strict Priority, Weighted Fair Queuing and Token Shaping

This block decides which of four egress queues may send its next frame. Every queue has a configuration byte: a 6-bit credit value in bits [5:0], a shaping switch in bit 6 and a weighted-fair mode switch in bit 7. A queue with neither switch set is served by strict priority, and queue 3 is the most urgent. A queue with bit 7 set competes in a weighted round robin that spends its credit. A queue with bit 6 set is rate limited by a token bucket that refills by its credit. While it holds tokens it outranks every other queue, and bit 6 overrides bit 7.

The transmit side raises `req` when it can start a frame. One cycle later the block returns a one-hot `gnt` qualified by `gnt_valid`. When the frame has gone, the transmit side pulses `tx_done` with the frame length in credit units. That length is charged to the queue of the most recent grant. The four credits are meant to add up to 64. Any other total raises `cfg_err`, and scheduling goes on with the values given.

Top module: `wfq_sp_sched`

## Requirements
- R1: After reset `gnt` is 0, `gnt_valid` is 0, and all token and credit counters are 0. A shaped queue therefore cannot be granted before its first refill.
- R2: A cycle with `req` high gives, on the next cycle, `gnt_valid` high and a one-hot `gnt` naming a queue that was non-empty, if any queue was eligible. Otherwise, and after any cycle with `req` low, `gnt_valid` is 0 and `gnt` is 0.
- R3: A non-empty shaped queue (bit 6 = 1) with a non-zero token count wins over all other queues. Among several such queues the highest index wins.
- R4: With no shaped queue ready, a non-empty strict queue (bits 7 and 6 both 0) wins over every weighted queue. Among strict queues the highest index wins.
- R5: A shaped queue whose token count is 0 is never granted, even when it is the only non-empty queue.
- R6: When bit 6 is set, bit 7 of the same byte has no effect. The queue is scheduled and charged only as a shaped queue.
- R7: Weighted queues (bit 7 = 1, bit 6 = 0) are served in round robin. The search starts at the index just above the last weighted grant, wraps modulo 4, and skips queues whose remaining credit is 0 while another candidate still has credit.
- R8: When every non-empty weighted queue has 0 remaining credit, the weighted grant reloads the counters of all weighted queues from their configured credit. If all configured credits are also 0, the round robin picks among the candidates regardless of credit.
- R9: Every REFILL_P cycles after reset, each queue's token count rises by its credit, saturating at 64.
- R10: A `tx_done` pulse subtracts `tx_len` from the queue of the latest grant. It takes from the token count if that queue is shaped, and from the remaining credit if it is weighted. Both saturate at 0.
- R11: `cfg_err` is 1 exactly when the four credit fields do not add up to 64. Grants are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_ne | input | NQ | Per-queue non-empty flags |
| q_cfg | input | NQ*8 | Configuration bytes, queue q in bits [8q+7:8q] |
| req | input | 1 | Request for a scheduling decision |
| tx_done | input | 1 | Frame finished, charge its length |
| tx_len | input | LEN_W | Finished frame length in credit units |
| gnt | output | NQ | One-hot granted queue |
| gnt_valid | output | 1 | Grant is valid |
| cfg_err | output | 1 | Credit total differs from 64 |

## Verification
Random non-empty masks and random mixes of the three queue modes show whether the class ordering of shaped, strict and weighted queues holds against a reference model. Credit sets that sum to 64, alternating with corrupted sets, show that the error flag and the grants do not interfere. Directed sequences cover several cases: a shaped queue that waits for its first refill, a shaped queue that is drained by one long frame, and queues with both mode bits set. A long idle stretch exposes the token ceiling. Back-to-back weighted grants with fixed frame lengths show the order of the round robin and the moment of the credit reload.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

   typedef enum logic [1:0] {
      QC_STRICT = 2'd0,
      QC_WFQ    = 2'd1,
      QC_SHAPED = 2'd2
   } qclass_e;

   // shaping overrides the weighted-fair switch
   function automatic qclass_e decode_class(input logic shp_en, input logic wfq_en);
      if (shp_en)
         return QC_SHAPED;
      if (wfq_en)
         return QC_WFQ;
      return QC_STRICT;
   endfunction

endpackage

// File: rtl/wsched_hi_pick.sv
module wsched_hi_pick #(
   parameter int NQ = 4
) (
   input  logic [NQ-1:0] mask,
   output logic [NQ-1:0] oh
);
   always_comb begin
      oh = '0;
      for (int i = 0; i < NQ; i++) begin
         if (mask[i]) begin
            oh    = '0;
            oh[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/wsched_tokens.sv
module wsched_tokens #(
   parameter int NQ       = 4,
   parameter int CRED_W   = 6,
   parameter int TOK_W    = 7,
   parameter int TOK_CAP  = 64,
   parameter int LEN_W    = 7,
   parameter int REFILL_P = 256
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NQ-1:0][CRED_W-1:0]    cred,
   input  logic [NQ-1:0]                shp,
   input  logic [NQ-1:0]                chg_oh,
   input  logic [LEN_W-1:0]             chg_len,
   output logic [NQ-1:0][TOK_W-1:0]     tok,
   output logic [NQ-1:0]                has_tok
);
   localparam int TCW = (REFILL_P > 1) ? $clog2(REFILL_P) : 1;
   localparam int SW  = ((TOK_W > LEN_W) ? TOK_W : LEN_W) + 2;

   logic [TCW-1:0] tcnt;
   logic           tick;

   assign tick = (tcnt == TCW'(REFILL_P - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         tcnt <= '0;
      else
         tcnt <= tick ? '0 : tcnt + 1'b1;
   end

   for (genvar g = 0; g < NQ; g++) begin : g_bucket
      logic [TOK_W-1:0] tq;
      logic [TOK_W-1:0] nxt;
      logic [SW-1:0]    t_w, l_w, after, sum;

      always_comb begin
         t_w   = SW'(tq);
         l_w   = SW'(chg_len);
         after = t_w;
         if (chg_oh[g] && shp[g])
            after = (t_w > l_w) ? t_w - l_w : '0;
         sum = after;
         if (tick)
            sum = after + SW'(cred[g]);
         nxt = (sum > SW'(TOK_CAP)) ? TOK_W'(TOK_CAP) : TOK_W'(sum);
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            tq <= '0;
         else
            tq <= nxt;
      end

      assign tok[g]     = tq;
      assign has_tok[g] = (tq != '0);
   end
endmodule

// File: rtl/wsched_wfq.sv
module wsched_wfq #(
   parameter int NQ     = 4,
   parameter int CRED_W = 6,
   parameter int LEN_W  = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NQ-1:0][CRED_W-1:0] cred,
   input  logic [NQ-1:0]             wmode,
   input  logic [NQ-1:0]             cand,
   input  logic                      fire,
   input  logic [NQ-1:0]             chg_oh,
   input  logic [LEN_W-1:0]          chg_len,
   output logic [NQ-1:0]             pick
);
   localparam int PW = (NQ > 1) ? $clog2(NQ) : 1;
   localparam int SW = ((CRED_W > LEN_W) ? CRED_W : LEN_W) + 1;

   logic [NQ-1:0][CRED_W-1:0] cnt;
   logic [NQ-1:0]             left, elig, src;
   logic                      need_rl;
   logic [PW-1:0]             ptr, ptr_nxt;

   for (genvar g = 0; g < NQ; g++) begin : g_left
      assign left[g] = cand[g] && (cnt[g] != '0);
      assign elig[g] = cand[g] && ((need_rl ? cred[g] : cnt[g]) != '0);
   end

   assign need_rl = (cand != '0) && (left == '0);
   assign src     = (elig != '0) ? elig : cand;

   always_comb begin
      logic found;
      int   idx;
      pick  = '0;
      found = 1'b0;
      for (int off = 1; off <= NQ; off++) begin
         idx = (int'(ptr) + off) % NQ;
         if (!found && src[idx]) begin
            pick[idx] = 1'b1;
            found     = 1'b1;
         end
      end
   end

   always_comb begin
      ptr_nxt = ptr;
      for (int i = 0; i < NQ; i++)
         if (pick[i])
            ptr_nxt = PW'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (fire)
         ptr <= ptr_nxt;
   end

   for (genvar g = 0; g < NQ; g++) begin : g_cnt
      logic [CRED_W-1:0] cq;
      logic [SW-1:0]     base;

      always_comb begin
         base = SW'((fire && need_rl && wmode[g]) ? cred[g] : cq);
         if (chg_oh[g] && wmode[g])
            base = (base > SW'(chg_len)) ? base - SW'(chg_len) : '0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            cq <= '0;
         else
            cq <= CRED_W'(base);
      end

      assign cnt[g] = cq;
   end
endmodule

// File: rtl/wfq_sp_sched.sv
module wfq_sp_sched
   import wsched_pkg::*;
#(
   parameter int NQ       = 4,
   parameter int CRED_W   = 6,
   parameter int LEN_W    = 7,
   parameter int TOK_CAP  = 64,
   parameter int CRED_SUM = 64,
   parameter int REFILL_P = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NQ-1:0]        q_ne,
   input  logic [NQ*8-1:0]      q_cfg,
   input  logic                 req,
   input  logic                 tx_done,
   input  logic [LEN_W-1:0]     tx_len,
   output logic [NQ-1:0]        gnt,
   output logic                 gnt_valid,
   output logic                 cfg_err
);
   localparam int CFG_W   = 8;
   localparam int SHP_BIT = CRED_W;
   localparam int WFQ_BIT = CRED_W + 1;
   localparam int TOK_W   = $clog2(TOK_CAP + 1);

   if (NQ < 2)                  begin : g_chk_nq  $error("NQ must be at least 2");        end
   if (CRED_W + 2 > CFG_W)      begin : g_chk_cw  $error("credit field too wide");        end
   if (REFILL_P < 1)            begin : g_chk_rp  $error("REFILL_P must be positive");    end
   if (LEN_W < 1)               begin : g_chk_lw  $error("LEN_W must be positive");       end

   logic [NQ-1:0][CRED_W-1:0] cred;
   logic [NQ-1:0]             shp_m, wfq_m, wmode, strict_m;
   logic [NQ-1:0]             has_tok, rdy_shp, strict_c, wfq_c;
   logic [NQ-1:0]             oh_shp, oh_strict, oh_wfq, sel;
   logic [NQ-1:0]             last_oh, chg_oh;
   logic [NQ-1:0][TOK_W-1:0]  tok_all;
   logic                      fire, wfq_fire;

   for (genvar g = 0; g < NQ; g++) begin : g_dec
      qclass_e cls;
      assign cred[g]     = q_cfg[g*CFG_W +: CRED_W];
      assign shp_m[g]    = q_cfg[g*CFG_W + SHP_BIT];
      assign wfq_m[g]    = q_cfg[g*CFG_W + WFQ_BIT];
      assign cls         = decode_class(shp_m[g], wfq_m[g]);
      assign wmode[g]    = (cls == QC_WFQ);
      assign strict_m[g] = (cls == QC_STRICT);
   end

   assign rdy_shp  = q_ne & shp_m & has_tok;
   assign strict_c = q_ne & strict_m;
   assign wfq_c    = q_ne & wmode;
   assign chg_oh   = tx_done ? last_oh : '0;

   wsched_tokens #(
      .NQ(NQ), .CRED_W(CRED_W), .TOK_W(TOK_W), .TOK_CAP(TOK_CAP),
      .LEN_W(LEN_W), .REFILL_P(REFILL_P)
   ) u_tokens (
      .clk(clk), .rst_n(rst_n), .cred(cred), .shp(shp_m),
      .chg_oh(chg_oh), .chg_len(tx_len), .tok(tok_all), .has_tok(has_tok)
   );

   wsched_hi_pick #(.NQ(NQ)) u_pick_shp    (.mask(rdy_shp),  .oh(oh_shp));
   wsched_hi_pick #(.NQ(NQ)) u_pick_strict (.mask(strict_c), .oh(oh_strict));

   assign wfq_fire = req && (rdy_shp == '0) && (strict_c == '0) && (wfq_c != '0);

   wsched_wfq #(.NQ(NQ), .CRED_W(CRED_W), .LEN_W(LEN_W)) u_wfq (
      .clk(clk), .rst_n(rst_n), .cred(cred), .wmode(wmode), .cand(wfq_c),
      .fire(wfq_fire), .chg_oh(chg_oh), .chg_len(tx_len), .pick(oh_wfq)
   );

   always_comb begin
      if (rdy_shp != '0)
         sel = oh_shp;
      else if (strict_c != '0)
         sel = oh_strict;
      else
         sel = oh_wfq;
   end

   assign fire = req && (sel != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt       <= '0;
         gnt_valid <= 1'b0;
         last_oh   <= '0;
      end else begin
         gnt       <= req ? sel : '0;
         gnt_valid <= fire;
         if (fire)
            last_oh <= sel;
      end
   end

   always_comb begin
      int s;
      s = 0;
      for (int i = 0; i < NQ; i++)
         s += int'(cred[i]);
      cfg_err = (s != CRED_SUM);
   end
endmodule

// File: rtl/wfq_sp_sched_chk.sv
module wfq_sp_sched_chk #(
   parameter int NQ      = 4,
   parameter int TOK_W   = 7,
   parameter int TOK_CAP = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NQ-1:0]            q_ne,
   input logic                     req,
   input logic [NQ-1:0]            gnt,
   input logic                     gnt_valid,
   input logic [NQ-1:0]            shp_m,
   input logic [NQ-1:0]            wfq_m,
   input logic [NQ-1:0][TOK_W-1:0] tok_all
);
   logic [NQ-1:0] strict_k, rdy_k;

   for (genvar g = 0; g < NQ; g++) begin : g_m
      assign strict_k[g] = q_ne[g] && !shp_m[g] && !wfq_m[g];
      assign rdy_k[g]    = q_ne[g] && shp_m[g] && (tok_all[g] != '0);
   end

   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> $onehot(gnt));

   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_valid |-> (gnt == '0));

   a_r2_cause: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> ($past(req) && ((gnt & $past(q_ne)) != '0)));

   for (genvar g = 0; g < NQ; g++) begin : g_a
      a_r5_token_held: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt[g] && $past(shp_m[g])) |-> ($past(tok_all[g]) != '0));

      a_r3_shaped_first: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt[g] && !$past(shp_m[g])) |-> ($past(rdy_k) == '0));

      a_r4_strict_before_wfq: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt[g] && $past(wfq_m[g] && !shp_m[g])) |-> ($past(strict_k) == '0));

      a_r9_token_cap: assert property (@(posedge clk) disable iff (!rst_n)
         tok_all[g] <= TOK_W'(TOK_CAP));
   end
endmodule

bind wfq_sp_sched wfq_sp_sched_chk #(
   .NQ(NQ), .TOK_W(TOK_W), .TOK_CAP(TOK_CAP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .q_ne(q_ne), .req(req), .gnt(gnt),
   .gnt_valid(gnt_valid), .shp_m(shp_m), .wfq_m(wfq_m), .tok_all(tok_all)
);

// File: tb/wfq_sp_sched_tb.sv
module wfq_sp_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NQ         = 4;
   localparam int LEN_W      = 7;
   localparam int RP         = 12;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NQ-1:0]     q_ne;
   logic [NQ*8-1:0]   q_cfg;
   logic              req, tx_done;
   logic [LEN_W-1:0]  tx_len;
   logic [NQ-1:0]     gnt;
   logic              gnt_valid, cfg_err;

   int n_tests = 0;
   int n_fail  = 0;

   int m_tok[NQ];
   int m_cnt[NQ];
   int m_ptr, m_tcnt, m_last;

   always #(CLK_PERIOD/2) clk = ~clk;

   wfq_sp_sched #(.NQ(NQ), .LEN_W(LEN_W), .REFILL_P(RP)) u_dut (
      .clk(clk), .rst_n(rst_n), .q_ne(q_ne), .q_cfg(q_cfg), .req(req),
      .tx_done(tx_done), .tx_len(tx_len), .gnt(gnt), .gnt_valid(gnt_valid),
      .cfg_err(cfg_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] qb(input bit wfq, input bit shp, input int c);
      return {wfq, shp, 6'(c)};
   endfunction

   function automatic logic [31:0] mk(input logic [7:0] b3, b2, b1, b0);
      return {b3, b2, b1, b0};
   endfunction

   // one cycle: drive at negedge, predict, clock, compare at next negedge
   task automatic step(input logic [3:0] ne, input logic [31:0] cfg, input bit rq,
                       input bit dn, input int ln, input string tag);
      int  cr[NQ];
      bit  sh[NQ], wf[NQ];
      bit  [3:0] srdy, sp, wc, el, src;
      bit  need, wfire, tick;
      int  sel, sum, b, t, idx;
      q_ne = ne; q_cfg = cfg; req = rq; tx_done = dn; tx_len = LEN_W'(ln);
      sum = 0;
      for (int q = 0; q < NQ; q++) begin
         cr[q] = int'(cfg[q*8 +: 6]);
         sh[q] = cfg[q*8 + 6];
         wf[q] = cfg[q*8 + 7];
         sum  += cr[q];
         srdy[q] = ne[q] && sh[q] && (m_tok[q] > 0);
         sp[q]   = ne[q] && !sh[q] && !wf[q];
         wc[q]   = ne[q] && !sh[q] && wf[q];
      end
      #1;
      chk("R11 cfg_err", int'(cfg_err), int'(sum != 64));
      need = (wc != 0);
      for (int q = 0; q < NQ; q++)
         if (wc[q] && m_cnt[q] > 0) need = 0;
      sel = -1; wfire = 0;
      if (rq) begin
         if (srdy != 0) begin
            for (int q = 0; q < NQ; q++) if (srdy[q]) sel = q;
         end else if (sp != 0) begin
            for (int q = 0; q < NQ; q++) if (sp[q]) sel = q;
         end else if (wc != 0) begin
            wfire = 1;
            for (int q = 0; q < NQ; q++) el[q] = wc[q] && ((need ? cr[q] : m_cnt[q]) > 0);
            src = (el != 0) ? el : wc;
            for (int off = NQ; off >= 1; off--) begin
               idx = (m_ptr + off) % NQ;
               if (src[idx]) sel = idx;
            end
         end
      end
      tick = (m_tcnt == RP - 1);
      for (int q = 0; q < NQ; q++) begin
         b = (wfire && need && !sh[q] && wf[q]) ? cr[q] : m_cnt[q];
         if (dn && m_last == q && !sh[q] && wf[q]) b = (b > ln) ? b - ln : 0;
         m_cnt[q] = b;
         t = m_tok[q];
         if (dn && m_last == q && sh[q]) t = (t > ln) ? t - ln : 0;
         if (tick) t = (t + cr[q] > 64) ? 64 : t + cr[q];
         m_tok[q] = t;
      end
      if (sel >= 0) m_last = sel;
      if (wfire) m_ptr = sel;
      m_tcnt = tick ? 0 : m_tcnt + 1;
      @(posedge clk);
      @(negedge clk);
      chk(tag, int'(gnt), (sel >= 0) ? (1 << sel) : 0);
      chk(tag, int'(gnt_valid), int'(sel >= 0));
   endtask

   function automatic logic [31:0] rand_cfg(input bit bad);
      int c0, c1, c2, c3;
      c0 = 1 + int'($urandom % 16);
      c1 = 1 + int'($urandom % 16);
      c2 = 1 + int'($urandom % 16);
      c3 = 64 - c0 - c1 - c2;
      if (bad) c3 = (c3 + 1 + int'($urandom % 5)) % 64;
      return mk(qb($urandom % 3 == 0, $urandom % 4 == 0, c3),
                qb($urandom % 3 == 0, $urandom % 4 == 0, c2),
                qb($urandom % 3 == 0, $urandom % 4 == 0, c1),
                qb($urandom % 3 == 0, $urandom % 4 == 0, c0));
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_tests++; n_fail++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] c_strict, c_wfq, c_shp;
      void'($urandom(32'd1234));
      for (int q = 0; q < NQ; q++) begin m_tok[q] = 0; m_cnt[q] = 0; end
      m_ptr = 0; m_tcnt = 0; m_last = -1;
      rst_n = 0; q_ne = 0; q_cfg = mk(qb(0,0,16), qb(0,0,16), qb(0,0,16), qb(0,0,16));
      req = 0; tx_done = 0; tx_len = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset gnt", int'(gnt), 0);
      chk("R1 reset valid", int'(gnt_valid), 0);
      rst_n = 1;

      // R1: shaped queue has no tokens right after reset
      c_shp = mk(qb(0,0,16), qb(0,0,16), qb(0,0,16), qb(0,1,16));
      step(4'b0001, c_shp, 1, 0, 0, "R1 no token after reset");
      // R4: strict highest index wins
      c_strict = mk(qb(0,0,16), qb(0,0,16), qb(0,0,16), qb(0,0,16));
      step(4'b0101, c_strict, 1, 0, 0, "R4 strict hi index");
      // R2: no request -> nothing
      step(4'b1111, c_strict, 0, 0, 0, "R2 no request");
      step(4'b0000, c_strict, 1, 0, 0, "R2 nothing eligible");
      // R4: strict q1 beats weighted q3
      c_wfq = mk(qb(1,0,16), qb(0,0,16), qb(0,0,16), qb(0,0,16));
      step(4'b1010, c_wfq, 1, 0, 0, "R4 strict over wfq");
      // R9: wait for refill, shaped q0 then beats strict q3
      for (int i = 0; i < RP; i++) step(4'b0000, c_shp, 0, 0, 0, "R9 idle refill");
      step(4'b1001, c_shp, 1, 0, 0, "R3 shaped first");
      // R10/R5: drain q0 tokens with a long frame
      step(4'b0000, c_shp, 0, 1, 100, "R10 charge shaped");
      step(4'b0001, c_shp, 1, 0, 0, "R5 drained shaped blocked");
      // R6: q1 has both bits, acts as shaped; others weighted
      for (int i = 0; i < RP; i++) step(4'b0000, mk(qb(1,0,16), qb(1,0,16), qb(1,1,16), qb(1,0,16)), 0, 0, 0, "R9 idle refill");
      step(4'b1111, mk(qb(1,0,16), qb(1,0,16), qb(1,1,16), qb(1,0,16)), 1, 0, 0, "R6 shaper overrides wfq");
      // R7/R8: all weighted, credits 40/8/8/8, frames of 8
      c_wfq = mk(qb(1,0,8), qb(1,0,8), qb(1,0,8), qb(1,0,40));
      for (int i = 0; i < 16; i++) step(4'b1111, c_wfq, 1, 1, 8, "R7 R8 weighted rr reload");
      // R8: zero configured credits still served
      step(4'b0110, mk(qb(1,0,32), qb(1,0,0), qb(1,0,0), qb(1,0,32)), 1, 1, 8, "R8 zero credit fallback");
      step(4'b0110, mk(qb(1,0,32), qb(1,0,0), qb(1,0,0), qb(1,0,32)), 1, 1, 8, "R8 zero credit fallback");
      // R9: long idle, token cap 64 on credit 40, then frames of 20
      c_shp = mk(qb(0,0,8), qb(0,0,8), qb(0,0,8), qb(0,1,40));
      for (int i = 0; i < RP * 5; i++) step(4'b0000, c_shp, 0, 0, 0, "R9 idle cap");
      for (int i = 0; i < 8; i++) step(4'b0011, c_shp, 1, 1, 20, "R9 token cap");
      // R11: bad credit sum, scheduling continues
      step(4'b0100, mk(qb(0,0,1), qb(0,0,1), qb(0,0,1), qb(0,0,1)), 1, 0, 0, "R11 bad sum still grants");
      // random mix
      for (int i = 0; i < 3000; i++)
         step(4'($urandom), rand_cfg($urandom % 8 == 0), $urandom % 4 != 0,
              $urandom % 3 == 0, 1 + int'($urandom % 24), "R2 random mix");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule